// File: doc/BRIEF.md
# Debug and Boot Control Register Bank

This block is a small Wishbone slave placed next to an 8-bit processor core. It holds four 32-bit registers: a cycle counter that runs freely, a debug-options word, a boot address window and a boot-control word. Bus cycles complete in one clock. Writes honour the byte selects, and reads of any address that is not mapped return zero and are still acknowledged.

The block also owns the side-band logic that these registers steer. A strobe multiplexer can replace the processor's data and control I/O strobes with status flags for probing. A write-enable shaper can narrow the external write pulse to either clock phase. A reset selector can hold the processor in reset, or release it, independently of the external reset pin. A test override can take the general-purpose pin 3. The remaining fields go out as plain configuration: the SRAM enable, the boot window, the flash chip-select index and the boot enable.

Top module: `dbgctl_bank`

## Requirements
- R1: A request (cyc and stb high, ack low) raises ack on the next cycle for exactly one cycle. A read from an address other than 0x30400000, 0x30200000, 0x30100000 or 0x30180000 returns zero.
- R2: The counter at 0x30400000 increases by one every clock and wraps from 0xFFFFFFFF to 0. Reads return the count held at the edge that accepts the request.
- R3: A full-width write to the counter loads the written value, and counting resumes from it on the next cycle.
- R4: On a write, only the bytes whose select bit is 1 change; sel bit n covers data bits 8n+7:8n.
- R5: Reserved bits read as zero and ignore writes: bits 31:9 of the debug word at 0x30200000, and bits 30:3 of the boot-control word at 0x30180000.
- R6: After synchronous active-low reset, all registers and all configuration outputs are zero.
- R7: When debug bit 0 is set, iod_o shows cc_i[0] and ioc_o shows cc_i[1]. This takes priority over bit 1.
- R8: When debug bit 1 alone is set, iod_o shows carry_i and ioc_o shows idc_i. When neither bit is set, the raw strobes pass through.
- R9: With write-enable mode (debug bits 3:2) equal to 0 or 3, we_o follows we_raw_i over the whole cycle.
- R10: Mode 1 passes we_raw_i only while the clock is low, and mode 2 passes it only while the clock is high.
- R11: With debug bit 4 set, cpu_rst_o equals debug bit 5 (1 means reset). With bit 4 clear, cpu_rst_o equals ext_rst_i.
- R12: With debug bit 6 set, pin3_o equals debug bit 7 and pin3_oe_o is 1. Otherwise both pass the default inputs through.
- R13: Debug bit 8 drives sram_en_o. Bits 15:0 and 31:16 at 0x30100000 drive boot_start_o and boot_end_o. Bits 2:0 and bit 31 at 0x30180000 drive flash_cs_sel_o and boot_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when 1 |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte selects |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| cc_i | input | 2 | Processor condition code |
| carry_i | input | 1 | Processor carry flag |
| idc_i | input | 1 | Processor inter-digit carry |
| iod_raw_i | input | 1 | Raw data I/O strobe |
| ioc_raw_i | input | 1 | Raw control I/O strobe |
| iod_o | output | 1 | Data strobe after the multiplexer |
| ioc_o | output | 1 | Control strobe after the multiplexer |
| we_raw_i | input | 1 | Full-cycle write enable from the processor |
| we_o | output | 1 | Shaped write enable |
| ext_rst_i | input | 1 | External processor reset, active high |
| cpu_rst_o | output | 1 | Processor reset, active high |
| pin3_dflt_i | input | 1 | Default value for pin 3 |
| pin3_dflt_oe_i | input | 1 | Default output enable for pin 3 |
| pin3_o | output | 1 | Pin 3 value |
| pin3_oe_o | output | 1 | Pin 3 output enable |
| sram_en_o | output | 1 | Internal SRAM enable |
| boot_start_o | output | 16 | First boot address, inclusive |
| boot_end_o | output | 16 | Last boot address, inclusive |
| flash_cs_sel_o | output | 3 | Index of the port-B bit that serves as flash chip select |
| boot_en_o | output | 1 | Boot ROM enable |

## Verification
A wrong stored bit shows up at the ports in one of two ways. If it sits in a side-band field, it corrupts iod_o, ioc_o, we_o, cpu_rst_o or the pin-3 pair at once, because those paths are combinational from the register. A wrong bit anywhere is also seen at the next read of its register, two cycles after the request is presented. Counter faults appear as a wrong step between two reads taken a fixed number of cycles apart, or as a wrong value just after a load or a wrap. Phase faults in the shaper are visible only inside a cycle, so we_o is sampled once in each clock half.

// File: rtl/dbgctl_pkg.sv
// Shared addresses, field layout and helpers for the debug/boot register bank.
// Assumes a 32-bit Wishbone data path with byte-granular selects.
package dbgctl_pkg;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    localparam logic [DW-1:0] ADDR_COUNT = 32'h3040_0000;
    localparam logic [DW-1:0] ADDR_DEBUG = 32'h3020_0000;
    localparam logic [DW-1:0] ADDR_RANGE = 32'h3010_0000;
    localparam logic [DW-1:0] ADDR_BOOT  = 32'h3018_0000;

    typedef enum logic [1:0] {
        WE_FULL = 2'd0,
        WE_LOW  = 2'd1,
        WE_HIGH = 2'd2,
        WE_ALT  = 2'd3
    } we_mode_e;

    // Debug word, bit 8 down to bit 0.
    typedef struct packed {
        logic     sram_en;     // 8
        logic     pin3_state;  // 7
        logic     pin3_test;   // 6
        logic     rst_val;     // 5
        logic     rst_en;      // 4
        we_mode_e we_mode;     // 3:2
        logic     dbg_carry;   // 1
        logic     dbg_cc;      // 0
    } dbg_cfg_t;

    localparam int CFG_W = $bits(dbg_cfg_t);

    // Replace the selected bytes of an old word with new data.
    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                  input logic [DW-1:0] new_v,
                                                  input logic [SW-1:0] sel);
        logic [DW-1:0] r;
        for (int b = 0; b < SW; b++) begin
            r[b*8 +: 8] = sel[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/dbgctl_regs.sv
// Wishbone register file: cycle counter, debug word, boot window, boot control.
// Assumes a single-cycle classic slave; ack follows each request by one cycle.
module dbgctl_regs
    import dbgctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CS_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [DW-1:0]     wb_adr_i,
    input  logic [DW-1:0]     wb_dat_i,
    input  logic [SW-1:0]     wb_sel_i,
    output logic [DW-1:0]     wb_dat_o,
    output logic              wb_ack_o,
    output dbg_cfg_t          cfg_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] end_o,
    output logic [CS_W-1:0]   cs_o,
    output logic              boot_en_o,
    output logic [DW-1:0]     count_o
);
    localparam int RANGE_W = 2 * ADDR_W;

    logic [DW-1:0]      count_q;
    dbg_cfg_t           cfg_q;
    logic [RANGE_W-1:0] range_q;
    logic [CS_W-1:0]    cs_q;
    logic               boot_en_q;
    logic               req;
    logic [DW-1:0]      rd_data;
    logic [DW-1:0]      boot_word;
    logic [DW-1:0]      m_count, m_debug, m_range, m_boot;

    // New request when the bus is active and the previous one is acked.
    assign req = wb_cyc_i && wb_stb_i && !wb_ack_o;

    // Assemble the boot-control word with reserved bits at zero.
    always_comb begin
        boot_word           = '0;
        boot_word[DW-1]     = boot_en_q;
        boot_word[CS_W-1:0] = cs_q;
    end

    // Byte-merged write values for each register.
    always_comb begin
        m_count = merge_bytes(count_q, wb_dat_i, wb_sel_i);
        m_debug = merge_bytes(DW'(cfg_q), wb_dat_i, wb_sel_i);
        m_range = merge_bytes(DW'(range_q), wb_dat_i, wb_sel_i);
        m_boot  = merge_bytes(boot_word, wb_dat_i, wb_sel_i);
    end

    // Read multiplexer: unmapped addresses return zero.
    always_comb begin
        unique case (wb_adr_i)
            ADDR_COUNT: rd_data = count_q;
            ADDR_DEBUG: rd_data = DW'(cfg_q);
            ADDR_RANGE: rd_data = DW'(range_q);
            ADDR_BOOT:  rd_data = boot_word;
            default:    rd_data = '0;
        endcase
    end

    // Counter: free-running, loaded on a write to its address.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (req && wb_we_i && wb_adr_i == ADDR_COUNT) begin
            count_q <= m_count;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // Configuration registers: written through byte selects.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q     <= '0;
            range_q   <= '0;
            cs_q      <= '0;
            boot_en_q <= 1'b0;
        end else if (req && wb_we_i) begin
            if (wb_adr_i == ADDR_DEBUG) cfg_q   <= dbg_cfg_t'(m_debug[CFG_W-1:0]);
            if (wb_adr_i == ADDR_RANGE) range_q <= m_range[RANGE_W-1:0];
            if (wb_adr_i == ADDR_BOOT) begin
                cs_q      <= m_boot[CS_W-1:0];
                boot_en_q <= m_boot[DW-1];
            end
        end
    end

    // Bus response: one-cycle ack, read data captured with it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack_o <= req;
            if (req && !wb_we_i) wb_dat_o <= rd_data;
        end
    end

    assign cfg_o     = cfg_q;
    assign start_o   = range_q[ADDR_W-1:0];
    assign end_o     = range_q[RANGE_W-1:ADDR_W];
    assign cs_o      = cs_q;
    assign boot_en_o = boot_en_q;
    assign count_o   = count_q;
endmodule

// File: rtl/dbgctl_strobe_mux.sv
// Replaces processor I/O strobes with status flags while debugging, and
// selects the processor reset and the pin-3 drive. Purely combinational.
// Assumes software sets at most one of the two debug bits; cc wins otherwise.
module dbgctl_strobe_mux
    import dbgctl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  dbg_cfg_t         cfg_i,
    input  logic [LANES-1:0] raw_i,
    input  logic [LANES-1:0] cc_src_i,
    input  logic [LANES-1:0] carry_src_i,
    output logic [LANES-1:0] strobe_o,
    input  logic             ext_rst_i,
    output logic             cpu_rst_o,
    input  logic             pin3_dflt_i,
    input  logic             pin3_dflt_oe_i,
    output logic             pin3_o,
    output logic             pin3_oe_o
);
    // One selector per strobe lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            if (cfg_i.dbg_cc)         strobe_o[l] = cc_src_i[l];
            else if (cfg_i.dbg_carry) strobe_o[l] = carry_src_i[l];
            else                      strobe_o[l] = raw_i[l];
        end
    end

    // Processor reset: override value or external pin.
    always_comb cpu_rst_o = cfg_i.rst_en ? cfg_i.rst_val : ext_rst_i;

    // Pin 3: test drive or default function.
    always_comb begin
        pin3_o    = cfg_i.pin3_test ? cfg_i.pin3_state : pin3_dflt_i;
        pin3_oe_o = cfg_i.pin3_test ? 1'b1 : pin3_dflt_oe_i;
    end
endmodule

// File: rtl/dbgctl_we_shaper.sv
// Shapes the external write enable: full cycle, low phase only or high phase
// only. Assumes the raw enable is a registered full-cycle pulse and that
// the clock is a clean square wave; the output is gated by the clock level.
module dbgctl_we_shaper
    import dbgctl_pkg::*;
(
    input  logic     clk_i,
    input  we_mode_e mode_i,
    input  logic     we_raw_i,
    output logic     we_o
);
    // Gate by clock phase according to mode; mode 3 acts as full width.
    always_comb begin
        unique case (mode_i)
            WE_LOW:  we_o = we_raw_i & ~clk_i;
            WE_HIGH: we_o = we_raw_i & clk_i;
            default: we_o = we_raw_i;
        endcase
    end
endmodule

// File: rtl/dbgctl_bank.sv
// Top of the debug/boot register bank: Wishbone registers plus the
// side-band strobe, write-enable, reset and pin-3 logic they control.
// Assumes a single clock domain shared with the processor core.
module dbgctl_bank
    import dbgctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CS_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [31:0]       wb_adr_i,
    input  logic [31:0]       wb_dat_i,
    input  logic [3:0]        wb_sel_i,
    output logic [31:0]       wb_dat_o,
    output logic              wb_ack_o,
    input  logic [1:0]        cc_i,
    input  logic              carry_i,
    input  logic              idc_i,
    input  logic              iod_raw_i,
    input  logic              ioc_raw_i,
    output logic              iod_o,
    output logic              ioc_o,
    input  logic              we_raw_i,
    output logic              we_o,
    input  logic              ext_rst_i,
    output logic              cpu_rst_o,
    input  logic              pin3_dflt_i,
    input  logic              pin3_dflt_oe_i,
    output logic              pin3_o,
    output logic              pin3_oe_o,
    output logic              sram_en_o,
    output logic [ADDR_W-1:0] boot_start_o,
    output logic [ADDR_W-1:0] boot_end_o,
    output logic [CS_W-1:0]   flash_cs_sel_o,
    output logic              boot_en_o
);
    dbg_cfg_t      cfg_w;
    logic [DW-1:0] count_w;
    logic [1:0]    strobe_w;

    dbgctl_regs #(.ADDR_W(ADDR_W), .CS_W(CS_W)) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wb_cyc_i  (wb_cyc_i),
        .wb_stb_i  (wb_stb_i),
        .wb_we_i   (wb_we_i),
        .wb_adr_i  (wb_adr_i),
        .wb_dat_i  (wb_dat_i),
        .wb_sel_i  (wb_sel_i),
        .wb_dat_o  (wb_dat_o),
        .wb_ack_o  (wb_ack_o),
        .cfg_o     (cfg_w),
        .start_o   (boot_start_o),
        .end_o     (boot_end_o),
        .cs_o      (flash_cs_sel_o),
        .boot_en_o (boot_en_o),
        .count_o   (count_w)
    );

    // Lane 0 is the data strobe, lane 1 the control strobe.
    dbgctl_strobe_mux #(.LANES(2)) mux_i (
        .cfg_i          (cfg_w),
        .raw_i          ({ioc_raw_i, iod_raw_i}),
        .cc_src_i       (cc_i),
        .carry_src_i    ({idc_i, carry_i}),
        .strobe_o       (strobe_w),
        .ext_rst_i      (ext_rst_i),
        .cpu_rst_o      (cpu_rst_o),
        .pin3_dflt_i    (pin3_dflt_i),
        .pin3_dflt_oe_i (pin3_dflt_oe_i),
        .pin3_o         (pin3_o),
        .pin3_oe_o      (pin3_oe_o)
    );

    dbgctl_we_shaper shaper_i (
        .clk_i    (clk_i),
        .mode_i   (cfg_w.we_mode),
        .we_raw_i (we_raw_i),
        .we_o     (we_o)
    );

    assign iod_o     = strobe_w[0];
    assign ioc_o     = strobe_w[1];
    assign sram_en_o = cfg_w.sram_en;
endmodule

// File: rtl/dbgctl_bank_chk.sv
// Property checker for dbgctl_bank, attached by bind below.
module dbgctl_bank_chk
    import dbgctl_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wb_cyc_i,
    input logic          wb_stb_i,
    input logic          wb_we_i,
    input logic [31:0]   wb_adr_i,
    input logic [31:0]   wb_dat_i,
    input logic [3:0]    wb_sel_i,
    input logic [31:0]   wb_dat_o,
    input logic          wb_ack_o,
    input logic [1:0]    cc_i,
    input logic          carry_i,
    input logic          idc_i,
    input logic          iod_o,
    input logic          ioc_o,
    input logic          we_raw_i,
    input logic          we_o,
    input logic          ext_rst_i,
    input logic          cpu_rst_o,
    input logic          pin3_o,
    input logic          pin3_oe_o,
    input dbg_cfg_t      cfg,
    input logic [DW-1:0] count
);
    logic req, ctr_wr, mapped;
    assign req    = wb_cyc_i && wb_stb_i && !wb_ack_o;
    assign ctr_wr = req && wb_we_i && wb_adr_i == ADDR_COUNT;
    assign mapped = wb_adr_i == ADDR_COUNT || wb_adr_i == ADDR_DEBUG ||
                    wb_adr_i == ADDR_RANGE || wb_adr_i == ADDR_BOOT;

    a_r1_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req |=> wb_ack_o);
    a_r1_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_ack_o |=> !wb_ack_o);
    a_r1_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req && !wb_we_i && !mapped) |=> wb_dat_o == '0);
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctr_wr |=> count == $past(count) + 32'd1);
    a_r3_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctr_wr && wb_sel_i == 4'hF) |=> count == $past(wb_dat_i));
    a_r5_debug_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req && !wb_we_i && wb_adr_i == ADDR_DEBUG) |=> wb_dat_o[31:9] == '0);
    a_r7_cc_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg.dbg_cc |-> (iod_o == cc_i[0] && ioc_o == cc_i[1]));
    a_r8_carry_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg.dbg_cc && cfg.dbg_carry) |-> (iod_o == carry_i && ioc_o == idc_i));
    a_r9_we_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.we_mode == WE_FULL || cfg.we_mode == WE_ALT) |-> we_o == we_raw_i);
    a_r11_rst_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg.rst_en |-> cpu_rst_o == cfg.rst_val);
    a_r11_rst_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg.rst_en |-> cpu_rst_o == ext_rst_i);
    a_r12_pin3_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg.pin3_test |-> (pin3_oe_o && pin3_o == cfg.pin3_state));
endmodule

bind dbgctl_bank dbgctl_bank_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wb_cyc_i  (wb_cyc_i),
    .wb_stb_i  (wb_stb_i),
    .wb_we_i   (wb_we_i),
    .wb_adr_i  (wb_adr_i),
    .wb_dat_i  (wb_dat_i),
    .wb_sel_i  (wb_sel_i),
    .wb_dat_o  (wb_dat_o),
    .wb_ack_o  (wb_ack_o),
    .cc_i      (cc_i),
    .carry_i   (carry_i),
    .idc_i     (idc_i),
    .iod_o     (iod_o),
    .ioc_o     (ioc_o),
    .we_raw_i  (we_raw_i),
    .we_o      (we_o),
    .ext_rst_i (ext_rst_i),
    .cpu_rst_o (cpu_rst_o),
    .pin3_o    (pin3_o),
    .pin3_oe_o (pin3_oe_o),
    .cfg       (cfg_w),
    .count     (count_w)
);

// File: tb/dbgctl_bank_tb_top.sv
// Directed bench for dbgctl_bank: one task per scenario.
module dbgctl_bank_tb_top;
    localparam time HALF = 10ns;
    localparam logic [31:0] A_CNT = 32'h3040_0000;
    localparam logic [31:0] A_DBG = 32'h3020_0000;
    localparam logic [31:0] A_RNG = 32'h3010_0000;
    localparam logic [31:0] A_BOOT = 32'h3018_0000;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic wb_cyc_i = 0, wb_stb_i = 0, wb_we_i = 0;
    logic [31:0] wb_adr_i = '0, wb_dat_i = '0;
    logic [3:0]  wb_sel_i = '0;
    logic [31:0] wb_dat_o;
    logic        wb_ack_o;
    logic [1:0]  cc_i = '0;
    logic carry_i = 0, idc_i = 0, iod_raw_i = 0, ioc_raw_i = 0;
    logic iod_o, ioc_o, we_o, cpu_rst_o, pin3_o, pin3_oe_o, sram_en_o, boot_en_o;
    logic we_raw_i = 0, ext_rst_i = 0, pin3_dflt_i = 0, pin3_dflt_oe_i = 0;
    logic [15:0] boot_start_o, boot_end_o;
    logic [2:0]  flash_cs_sel_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #HALF clk_i = ~clk_i;

    dbgctl_bank dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wb_write(logic [31:0] a, logic [31:0] d, logic [3:0] s);
        @(negedge clk_i);
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = a; wb_dat_i = d; wb_sel_i = s;
        @(posedge clk_i);
        @(negedge clk_i);
        wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
    endtask

    task automatic wb_read(logic [31:0] a, output logic [31:0] d, output logic ack);
        @(negedge clk_i);
        wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = a; wb_sel_i = 4'hF;
        @(posedge clk_i);
        @(negedge clk_i);
        d = wb_dat_o; ack = wb_ack_o;
        wb_cyc_i = 0; wb_stb_i = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic a;
        check("R6 sram_en", 32'(sram_en_o), 0);
        check("R6 boot_en", 32'(boot_en_o), 0);
        check("R6 boot window", {boot_end_o, boot_start_o}, 0);
        wb_read(A_DBG, d, a);
        check("R6 debug word", d, 0);
        wb_read(A_BOOT, d, a);
        check("R6 boot word", d, 0);
    endtask

    task automatic t_bus();
        logic [31:0] d; logic a;
        wb_write(A_RNG, 32'h1234_5678, 4'hF);
        wb_read(A_RNG, d, a);
        check("R1 ack", 32'(a), 1);
        @(negedge clk_i);
        check("R1 ack single", 32'(wb_ack_o), 0);
        wb_read(32'h3050_0000, d, a);
        check("R1 unmapped data", d, 0);
        check("R1 unmapped ack", 32'(a), 1);
    endtask

    task automatic t_counter();
        logic [31:0] d1, d2; logic a;
        wb_write(A_CNT, 32'h1000_0000, 4'hF);
        wb_read(A_CNT, d1, a);
        check("R3 load", d1, 32'h1000_0001);
        wb_read(A_CNT, d2, a);
        check("R2 step", d2 - d1, 2);
        wb_write(A_CNT, 32'hFFFF_FFFF, 4'hF);
        wb_read(A_CNT, d1, a);
        check("R2 wrap", d1, 0);
    endtask

    task automatic t_bytes();
        logic [31:0] d; logic a;
        wb_write(A_RNG, 32'h1234_5678, 4'hF);
        wb_write(A_RNG, 32'hAABB_CCDD, 4'b0100);
        wb_read(A_RNG, d, a);
        check("R4 byte select", d, 32'h12BB_5678);
        check("R13 boot_start", 32'(boot_start_o), 32'h5678);
        check("R13 boot_end", 32'(boot_end_o), 32'h12BB);
    endtask

    task automatic t_reserved();
        logic [31:0] d; logic a;
        wb_write(A_DBG, 32'hFFFF_FFFF, 4'hF);
        wb_read(A_DBG, d, a);
        check("R5 debug reserved", d, 32'h0000_01FF);
        wb_write(A_BOOT, 32'hFFFF_FFFF, 4'hF);
        wb_read(A_BOOT, d, a);
        check("R5 boot reserved", d, 32'h8000_0007);
        wb_write(A_BOOT, 32'h8000_0005, 4'hF);
        check("R13 cs index", 32'(flash_cs_sel_o), 5);
        check("R13 boot_en", 32'(boot_en_o), 1);
        wb_write(A_DBG, 32'h0000_0100, 4'hF);
        check("R13 sram_en", 32'(sram_en_o), 1);
    endtask

    task automatic t_strobes();
        wb_write(A_DBG, 32'h0, 4'hF);
        iod_raw_i = 1; ioc_raw_i = 0; cc_i = 2'b10; carry_i = 0; idc_i = 1;
        #1 check("R8 passthrough", {30'd0, ioc_o, iod_o}, 32'b01);
        wb_write(A_DBG, 32'h1, 4'hF);
        #1 check("R7 cc view", {30'd0, ioc_o, iod_o}, 32'b10);
        cc_i = 2'b01;
        #1 check("R7 cc view 2", {30'd0, ioc_o, iod_o}, 32'b01);
        wb_write(A_DBG, 32'h2, 4'hF);
        #1 check("R8 carry view", {30'd0, ioc_o, iod_o}, 32'b10);
        wb_write(A_DBG, 32'h3, 4'hF);
        #1 check("R7 cc priority", {30'd0, ioc_o, iod_o}, 32'b01);
    endtask

    task automatic we_phase(string req, logic exp_hi, logic exp_lo);
        @(posedge clk_i); #5;
        check({req, " high phase"}, 32'(we_o), 32'(exp_hi));
        @(negedge clk_i); #5;
        check({req, " low phase"}, 32'(we_o), 32'(exp_lo));
    endtask

    task automatic t_we();
        we_raw_i = 1;
        wb_write(A_DBG, 32'h0, 4'hF);
        we_phase("R9 mode0", 1, 1);
        wb_write(A_DBG, 32'hC, 4'hF);
        we_phase("R9 mode3", 1, 1);
        wb_write(A_DBG, 32'h4, 4'hF);
        we_phase("R10 mode1", 0, 1);
        wb_write(A_DBG, 32'h8, 4'hF);
        we_phase("R10 mode2", 1, 0);
        we_raw_i = 0;
        we_phase("R10 mode2 idle", 0, 0);
    endtask

    task automatic t_reset_ovr();
        ext_rst_i = 0;
        wb_write(A_DBG, 32'h30, 4'hF);
        #1 check("R11 override assert", 32'(cpu_rst_o), 1);
        ext_rst_i = 1;
        wb_write(A_DBG, 32'h10, 4'hF);
        #1 check("R11 override release", 32'(cpu_rst_o), 0);
        wb_write(A_DBG, 32'h20, 4'hF);
        #1 check("R11 pass high", 32'(cpu_rst_o), 1);
        ext_rst_i = 0;
        #1 check("R11 pass low", 32'(cpu_rst_o), 0);
    endtask

    task automatic t_pin3();
        pin3_dflt_i = 1; pin3_dflt_oe_i = 0;
        wb_write(A_DBG, 32'h0, 4'hF);
        #1 check("R12 default", {30'd0, pin3_oe_o, pin3_o}, 32'b01);
        wb_write(A_DBG, 32'h40, 4'hF);
        #1 check("R12 test drive 0", {30'd0, pin3_oe_o, pin3_o}, 32'b10);
        wb_write(A_DBG, 32'hC0, 4'hF);
        #1 check("R12 test drive 1", {30'd0, pin3_oe_o, pin3_o}, 32'b11);
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1;
        t_reset();
        t_bus();
        t_counter();
        t_bytes();
        t_reserved();
        t_strobes();
        t_we();
        t_reset_ovr();
        t_pin3();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule